// File: doc/BRIEF.md
# Wishbone Bridge to Register and Sample-Stream Accelerator Ports

This block is a Wishbone slave placed between a processor bus and an accelerator. The accelerator has a memory-mapped configuration port of the AXI-Lite kind and two AXI-Stream sample ports: one carries samples in and one carries results out. The bridge decodes the top byte of each Wishbone address. Requests in the accelerator window become a single AXI-Lite read or write. Two fixed offsets in that window become stream beats instead: a write to one offset pushes a sample, and a read from the other offset pops a result. Requests in a second window are forwarded unchanged to a separate Wishbone memory target.

Firmware finds out whether the streams are ready by reading the control word at offset 0. The bridge replaces two bits of the returned value with live stream status. Bit 4 reports that the accelerator can take a sample. Bit 5 reports that a result is waiting. Firmware polls these bits before it pushes or pops, so a stream access never blocks for long.

Only one transaction is in flight at any time. The bridge captures the request when it starts, and it returns a one-cycle acknowledge after the downstream handshake completes.

Top module: `wb_accel_bridge`

## Requirements
- R1: A request whose address top byte is 0x30 goes to the accelerator. A request whose top byte is 0x38 goes to the memory target. Any other request gets no acknowledge and causes no downstream valid, ready or strobe.
- R2: A write in the 0x30 window, other than the push offset, raises awvalid and wvalid together in the cycle after the request. It carries address bits [11:0], the write data, and wb_sel as wstrb. Each valid is held until its own ready and then dropped. After both are accepted, bready is raised, and the acknowledge follows one cycle after the B handshake.
- R3: A read in the 0x30 window, other than the pop offset, holds arvalid with a stable address until arready. It then raises rready. The acknowledge follows one cycle after the R handshake, and wb_dat_o equals rdata.
- R4: For a read of offset 0x000, the returned word has bit 4 set to in_tready and bit 5 set to out_tvalid, both as they are in the R handshake cycle. All other bits come from rdata.
- R5: A write to offset 0x080 raises in_tvalid in the cycle after the request, with in_tdata equal to the write data. Both are held stable until in_tready. The acknowledge follows one cycle after the handshake.
- R6: A read from offset 0x084 raises out_tready from the cycle after the request until exactly one beat is accepted. wb_dat_o then carries that beat's tdata together with the acknowledge.
- R7: Take an accelerator that accepts an address at once and returns read data two cycles after accepting the address. With it, a control-word read is acknowledged in the fifth cycle counted from the request cycle. With the stream peer ready, a push or a pop is acknowledged in the third cycle.
- R8: Once a transaction has started, changes to the Wishbone address or data inputs do not alter it, and no second downstream access starts before the acknowledge.
- R9: A request in the 0x38 window holds mem_cyc_o and mem_stb_o, with the latched address, data, write enable and select, until mem_ack_i. Read data is returned with the acknowledge one cycle later.
- R10: wb_ack_o is a single-cycle pulse. Write acknowledges return zero data.
- R11: During reset, wb_ack_o and every downstream valid, ready and strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | ADDR_W | Wishbone byte address |
| wb_dat_i | input | DATA_W | Wishbone write data |
| wb_sel_i | input | DATA_W/8 | Wishbone byte select |
| wb_dat_o | output | DATA_W | Wishbone read data |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| cfg_awvalid | output | 1 | Config write address valid |
| cfg_awready | input | 1 | Config write address ready |
| cfg_awaddr | output | LITE_AW | Config write address |
| cfg_wvalid | output | 1 | Config write data valid |
| cfg_wready | input | 1 | Config write data ready |
| cfg_wdata | output | DATA_W | Config write data |
| cfg_wstrb | output | DATA_W/8 | Config write strobes |
| cfg_bvalid | input | 1 | Config write response valid |
| cfg_bready | output | 1 | Config write response ready |
| cfg_arvalid | output | 1 | Config read address valid |
| cfg_arready | input | 1 | Config read address ready |
| cfg_araddr | output | LITE_AW | Config read address |
| cfg_rvalid | input | 1 | Config read data valid |
| cfg_rready | output | 1 | Config read data ready |
| cfg_rdata | input | DATA_W | Config read data |
| in_tvalid | output | 1 | Sample stream valid toward accelerator |
| in_tready | input | 1 | Sample stream ready from accelerator |
| in_tdata | output | DATA_W | Sample stream data |
| out_tvalid | input | 1 | Result stream valid from accelerator |
| out_tready | output | 1 | Result stream ready |
| out_tdata | input | DATA_W | Result stream data |
| mem_cyc_o | output | 1 | Memory target cycle |
| mem_stb_o | output | 1 | Memory target strobe |
| mem_we_o | output | 1 | Memory target write enable |
| mem_adr_o | output | ADDR_W | Memory target address |
| mem_dat_o | output | DATA_W | Memory target write data |
| mem_sel_o | output | DATA_W/8 | Memory target byte select |
| mem_dat_i | input | DATA_W | Memory target read data |
| mem_ack_i | input | 1 | Memory target acknowledge |

## Verification
Faults in the sequencer show up at the ports within a few cycles. A wrong next state shows as a missing or doubled acknowledge, or as a valid that drops before its ready; this appears in the cycle after the handshake. If the request latch is wrong, the stream data or address changes while a stalled beat waits, so a push held back by a low ready exposes it at once. A wrong status fold changes bits 4 and 5 of the control-word read. Running that read with each stream peer ready and not ready catches it in a single transaction.

// File: rtl/wb_accel_bridge.sv
module wb_accel_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LITE_AW = 12,
  parameter logic [7:0] ACC_REGION = 8'h30,
  parameter logic [7:0] MEM_REGION = 8'h38,
  parameter logic [11:0] CTRL_OFS = 12'h000,
  parameter logic [11:0] PUSH_OFS = 12'h080,
  parameter logic [11:0] POP_OFS = 12'h084,
  parameter int IN_RDY_BIT = 4,
  parameter int OUT_AVL_BIT = 5,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic [SEL_W-1:0]  wb_sel_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic               cfg_awvalid,
  input  logic               cfg_awready,
  output logic [LITE_AW-1:0] cfg_awaddr,
  output logic               cfg_wvalid,
  input  logic               cfg_wready,
  output logic [DATA_W-1:0]  cfg_wdata,
  output logic [SEL_W-1:0]   cfg_wstrb,
  input  logic               cfg_bvalid,
  output logic               cfg_bready,
  output logic               cfg_arvalid,
  input  logic               cfg_arready,
  output logic [LITE_AW-1:0] cfg_araddr,
  input  logic               cfg_rvalid,
  output logic               cfg_rready,
  input  logic [DATA_W-1:0]  cfg_rdata,
  output logic              in_tvalid,
  input  logic              in_tready,
  output logic [DATA_W-1:0] in_tdata,
  input  logic              out_tvalid,
  output logic              out_tready,
  input  logic [DATA_W-1:0] out_tdata,
  output logic              mem_cyc_o,
  output logic              mem_stb_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_adr_o,
  output logic [DATA_W-1:0] mem_dat_o,
  output logic [SEL_W-1:0]  mem_sel_o,
  input  logic [DATA_W-1:0] mem_dat_i,
  input  logic              mem_ack_i
);

  typedef enum logic [3:0] {
    S_IDLE, S_AR, S_R, S_AWW, S_B, S_PUSH, S_POP, S_MEM, S_RESP
  } st_t;

  st_t               state;
  logic [ADDR_W-1:0] req_adr;
  logic [DATA_W-1:0] req_dat;
  logic [SEL_W-1:0]  req_sel;
  logic              req_we;
  logic              aw_pend, w_pend;
  logic [DATA_W-1:0] rsp_dat;
  logic [DATA_W-1:0] folded;

  wire               req     = wb_cyc_i && wb_stb_i;
  wire [7:0]         region  = wb_adr_i[ADDR_W-1 -: 8];
  wire [LITE_AW-1:0] ofs     = wb_adr_i[LITE_AW-1:0];
  wire               hit_acc = region == ACC_REGION;
  wire               hit_mem = region == MEM_REGION;
  wire               is_ctrl = req_adr[LITE_AW-1:0] == CTRL_OFS;
  wire               aw_done = !aw_pend || cfg_awready;
  wire               w_done  = !w_pend || cfg_wready;

  always_comb begin
    folded = cfg_rdata;
    folded[IN_RDY_BIT]  = in_tready;
    folded[OUT_AVL_BIT] = out_tvalid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      req_adr <= '0;
      req_dat <= '0;
      req_sel <= '0;
      req_we  <= 1'b0;
      aw_pend <= 1'b0;
      w_pend  <= 1'b0;
      rsp_dat <= '0;
    end else begin
      case (state)
        S_IDLE: if (req && (hit_acc || hit_mem)) begin
          req_adr <= wb_adr_i;
          req_dat <= wb_dat_i;
          req_sel <= wb_sel_i;
          req_we  <= wb_we_i;
          rsp_dat <= '0;
          if (hit_mem) state <= S_MEM;
          else if (wb_we_i && ofs == PUSH_OFS) state <= S_PUSH;
          else if (!wb_we_i && ofs == POP_OFS) state <= S_POP;
          else if (wb_we_i) begin
            state   <= S_AWW;
            aw_pend <= 1'b1;
            w_pend  <= 1'b1;
          end else state <= S_AR;
        end
        S_AR: if (cfg_arready) state <= S_R;
        S_R: if (cfg_rvalid) begin
          rsp_dat <= is_ctrl ? folded : cfg_rdata;
          state   <= S_RESP;
        end
        S_AWW: begin
          if (cfg_awready) aw_pend <= 1'b0;
          if (cfg_wready) w_pend <= 1'b0;
          if (aw_done && w_done) state <= S_B;
        end
        S_B: if (cfg_bvalid) state <= S_RESP;
        S_PUSH: if (in_tready) state <= S_RESP;
        S_POP: if (out_tvalid) begin
          rsp_dat <= out_tdata;
          state   <= S_RESP;
        end
        S_MEM: if (mem_ack_i) begin
          rsp_dat <= req_we ? '0 : mem_dat_i;
          state   <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wb_ack_o    = state == S_RESP;
  assign wb_dat_o    = rsp_dat;
  assign cfg_awvalid = state == S_AWW && aw_pend;
  assign cfg_wvalid  = state == S_AWW && w_pend;
  assign cfg_awaddr  = req_adr[LITE_AW-1:0];
  assign cfg_araddr  = req_adr[LITE_AW-1:0];
  assign cfg_wdata   = req_dat;
  assign cfg_wstrb   = req_sel;
  assign cfg_bready  = state == S_B;
  assign cfg_arvalid = state == S_AR;
  assign cfg_rready  = state == S_R;
  assign in_tvalid   = state == S_PUSH;
  assign in_tdata    = req_dat;
  assign out_tready  = state == S_POP;
  assign mem_cyc_o   = state == S_MEM;
  assign mem_stb_o   = state == S_MEM;
  assign mem_we_o    = req_we;
  assign mem_adr_o   = req_adr;
  assign mem_dat_o   = req_dat;
  assign mem_sel_o   = req_sel;

  p_aw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_awvalid && !cfg_awready |=> cfg_awvalid && $stable(cfg_awaddr));
  p_ack_after_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bvalid && cfg_bready |=> wb_ack_o);
  p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_arvalid && !cfg_arready |=> cfg_arvalid && $stable(cfg_araddr));
  p_ack_after_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid && cfg_rready |=> wb_ack_o);
  p_push_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_tvalid && !in_tready |=> in_tvalid && $stable(in_tdata));
  p_pop_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid && out_tready |=> !out_tready && wb_ack_o && wb_dat_o == $past(out_tdata));
  p_mem_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stb_o && mem_ack_i |=> wb_ack_o && !mem_stb_o);
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o);
  p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_arvalid | cfg_rready, cfg_awvalid | cfg_wvalid | cfg_bready,
              in_tvalid, out_tready, mem_stb_o, wb_ack_o}));

endmodule

// File: tb/test_wb_accel_bridge.sv
module test_wb_accel_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam logic [97:0] VEC [0:NV-1] = '{
    {2'd0, 32'h3000_0010, 32'h1111_2222, 32'h0},
    {2'd0, 32'h3000_0014, 32'hDEAD_BEEF, 32'h0},
    {2'd1, 32'h3000_0010, 32'h0,         32'h1111_2222},
    {2'd1, 32'h3000_0014, 32'h0,         32'hDEAD_BEEF},
    {2'd0, 32'h3800_0040, 32'h0BAD_F00D, 32'h0},
    {2'd1, 32'h3800_0040, 32'h0,         32'h0BAD_F00D},
    {2'd2, 32'h3000_0080, 32'h0000_0123, 32'h0000_0123},
    {2'd1, 32'h3000_0084, 32'h0,         32'hA000_0000},
    {2'd1, 32'h3000_0084, 32'h0,         32'hA000_0001},
    {2'd0, 32'h3000_0000, 32'h0,         32'h0},
    {2'd1, 32'h3000_0000, 32'h0,         32'h0000_0030},
    {2'd2, 32'h3000_0080, 32'hCAFE_0001, 32'hCAFE_0001}
  };

  logic clk = 0, rst_n = 0;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [31:0] wb_adr = 0, wb_dat_w = 0, wb_dat_r;
  logic [3:0] wb_sel = 4'hF;
  logic wb_ack;
  logic awvalid, awready, wvalid, wready, bvalid, bready, arvalid, arready, rvalid, rready;
  logic [11:0] awaddr, araddr;
  logic [31:0] wdata, rdata;
  logic [3:0] wstrb;
  logic in_tvalid, in_tready, out_tvalid, out_tready;
  logic [31:0] in_tdata, out_tdata;
  logic mem_cyc, mem_stb, mem_we, mem_ack;
  logic [31:0] mem_adr, mem_dat_w, mem_dat_r;
  logic [3:0] mem_sel;

  logic aw_rdy = 1, sink_rdy = 1, src_en = 1;
  logic [31:0] lite_regs [16];
  logic [31:0] mem_regs [16];
  logic got_aw, got_w, rd_pend;
  logic [11:0] aw_q, ar_q, last_awaddr;
  logic [31:0] w_q, sink_last, src_idx;
  logic [3:0] last_wstrb;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_accel_bridge i_wb_accel_bridge (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we), .wb_adr_i(wb_adr),
    .wb_dat_i(wb_dat_w), .wb_sel_i(wb_sel), .wb_dat_o(wb_dat_r), .wb_ack_o(wb_ack),
    .cfg_awvalid(awvalid), .cfg_awready(awready), .cfg_awaddr(awaddr),
    .cfg_wvalid(wvalid), .cfg_wready(wready), .cfg_wdata(wdata), .cfg_wstrb(wstrb),
    .cfg_bvalid(bvalid), .cfg_bready(bready),
    .cfg_arvalid(arvalid), .cfg_arready(arready), .cfg_araddr(araddr),
    .cfg_rvalid(rvalid), .cfg_rready(rready), .cfg_rdata(rdata),
    .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tdata(in_tdata),
    .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tdata(out_tdata),
    .mem_cyc_o(mem_cyc), .mem_stb_o(mem_stb), .mem_we_o(mem_we), .mem_adr_o(mem_adr),
    .mem_dat_o(mem_dat_w), .mem_sel_o(mem_sel), .mem_dat_i(mem_dat_r), .mem_ack_i(mem_ack)
  );

  assign awready = aw_rdy;
  assign wready = 1'b1;
  assign arready = 1'b1;
  assign in_tready = sink_rdy;
  assign out_tvalid = src_en;
  assign out_tdata = 32'hA000_0000 + src_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      got_aw <= 0; got_w <= 0; bvalid <= 0; rd_pend <= 0; rvalid <= 0; rdata <= 0;
      mem_ack <= 0; mem_dat_r <= 0; sink_last <= 0; src_idx <= 0;
      last_awaddr <= 0; last_wstrb <= 0; aw_q <= 0; ar_q <= 0; w_q <= 0;
      for (int i = 0; i < 16; i++) begin lite_regs[i] <= 0; mem_regs[i] <= 0; end
    end else begin
      if (awvalid && awready) begin got_aw <= 1; aw_q <= awaddr; last_awaddr <= awaddr; end
      if (wvalid && wready) begin got_w <= 1; w_q <= wdata; last_wstrb <= wstrb; end
      if (got_aw && got_w && !bvalid) begin
        lite_regs[aw_q[5:2]] <= w_q; bvalid <= 1; got_aw <= 0; got_w <= 0;
      end
      if (bvalid && bready) bvalid <= 0;
      if (arvalid && arready) begin rd_pend <= 1; ar_q <= araddr; end
      if (rd_pend) begin rvalid <= 1; rdata <= lite_regs[ar_q[5:2]]; rd_pend <= 0; end
      if (rvalid && rready) rvalid <= 0;
      mem_ack <= mem_stb && !mem_ack;
      if (mem_stb && !mem_ack) begin
        if (mem_we) mem_regs[mem_adr[5:2]] <= mem_dat_w;
        mem_dat_r <= mem_regs[mem_adr[5:2]];
      end
      if (in_tvalid && in_tready) sink_last <= in_tdata;
      if (out_tvalid && out_tready) src_idx <= src_idx + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic we, input logic [31:0] adr, input logic [31:0] dat,
                       input logic [3:0] sel);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_dat_w = dat; wb_sel = sel;
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    while (n < 64) begin
      @(posedge clk); @(negedge clk); n++;
      if (wb_ack) break;
    end
    if (!wb_ack) n = -1;
    wb_cyc = 0; wb_stb = 0;
  endtask

  task automatic xfer(input logic we, input logic [31:0] adr, input logic [31:0] dat,
                      output logic [31:0] rd, output int n);
    start(we, adr, dat, 4'hF);
    wait_ack(n);
    rd = wb_dat_r;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n;
    repeat (3) @(negedge clk);
    check("R11 outputs in reset", {27'd0, wb_ack, awvalid | wvalid | bready,
          arvalid | rready, in_tvalid | out_tready, mem_stb}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] kind;
      logic [31:0] adr, dat, exp;
      string tag;
      {kind, adr, dat, exp} = VEC[v];
      tag = adr[31:24] == 8'h38 ? "R9 memory window" :
            kind == 2 ? "R5 push" : adr[11:0] == 12'h084 ? "R6 pop" :
            adr[11:0] == 12'h000 && kind == 1 ? "R4 status fold" :
            kind == 1 ? "R3 lite read" : "R2 lite write";
      xfer(kind != 1, adr, dat, rd, n);
      check({tag, " ack seen"}, {31'd0, n > 0}, 32'd1);
      if (kind == 1) check(tag, rd, exp);
      else if (kind == 2) begin
        check(tag, sink_last, exp);
        check("R10 write ack data zero", rd, 32'd0);
      end
    end

    xfer(1'b0, 32'h3000_0000, 0, rd, n);
    check("R7 control read ack cycle", n + 1, 5);
    xfer(1'b1, 32'h3000_0080, 32'h1, rd, n);
    check("R7 push ack cycle", n + 1, 3);
    xfer(1'b0, 32'h3000_0084, 0, rd, n);
    check("R7 pop ack cycle", n + 1, 3);

    xfer(1'b1, 32'h3000_0000, 32'hFFFF_FFFF, rd, n);
    sink_rdy = 0; src_en = 0;
    xfer(1'b0, 32'h3000_0000, 0, rd, n);
    check("R4 status bits both low", rd, 32'hFFFF_FFCF);
    sink_rdy = 1;
    xfer(1'b0, 32'h3000_0000, 0, rd, n);
    check("R4 input ready only", rd, 32'hFFFF_FFDF);
    src_en = 1;

    sink_rdy = 0;
    start(1'b1, 32'h3000_0080, 32'h55, 4'hF);
    repeat (4) @(negedge clk);
    check("R5 stalled push holds", {in_tvalid, wb_ack, in_tdata[29:0]}, {2'b10, 30'h55});
    wb_dat_w = 32'h99; wb_adr = 32'h3800_0000;
    repeat (2) @(negedge clk);
    check("R8 latched data during stall", in_tdata, 32'h55);
    check("R8 no second access", {31'd0, mem_stb}, 32'd0);
    sink_rdy = 1;
    wait_ack(n);
    check("R5 stalled push delivered", sink_last, 32'h55);

    begin
      logic [31:0] idx0;
      src_en = 0;
      idx0 = src_idx;
      start(1'b0, 32'h3000_0084, 0, 4'hF);
      repeat (3) @(negedge clk);
      check("R6 pop waits for data", {30'd0, out_tready, wb_ack}, 32'd2);
      src_en = 1;
      wait_ack(n);
      check("R6 pop data", wb_dat_r, 32'hA000_0000 + idx0);
      @(negedge clk);
      check("R6 exactly one beat", src_idx - idx0, 32'd1);
      check("R6 ready dropped", {31'd0, out_tready}, 32'd0);
    end

    start(1'b0, 32'h4000_0010, 0, 4'hF);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R1 unmapped ignored", {26'd0, wb_ack, awvalid | wvalid, arvalid,
            in_tvalid, out_tready, mem_stb}, 32'd0);
    end
    wb_cyc = 0; wb_stb = 0;
    @(negedge clk);

    aw_rdy = 0;
    start(1'b1, 32'h3000_0018, 32'h77, 4'b0101);
    repeat (2) @(negedge clk);
    check("R2 aw held, w dropped", {29'd0, awvalid, wvalid, wb_ack}, 32'd4);
    aw_rdy = 1;
    wait_ack(n);
    check("R2 wstrb from sel", {28'd0, last_wstrb}, 32'h5);
    check("R2 awaddr low bits", {20'd0, last_awaddr}, 32'h018);
    xfer(1'b0, 32'h3000_0018, 0, rd, n);
    check("R2 split write readback", rd, 32'h77);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule